// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a small write-back data cache. A direct-mapped main array answers in the cycle a request is presented. Beside it sits a fully associative buffer of four lines that holds only lines pushed out of the main array. When the main array misses, every buffered line's address is compared at once. A match swaps the buffered line with the conflicting main line in a short, fixed sequence, so no trip to memory is needed. Only when both miss does the block fetch a line from the next level. The displaced main line then goes into the buffer, and a dirty buffered line that has to make room is written out first.

The processor holds a request (valid, word address, write enable, write data) until the block raises ready. The memory side carries line-sized read and write requests with a valid/ready handshake, plus a one-cycle response strobe that returns read data.

Top module: `vc_cache_top`

## Requirements
- R1: A request whose line is in the main array gets req_ready_o in the same cycle it is presented. A read returns the stored word. A write replaces that word and marks the line dirty.
- R2: req_addr_i is a word address. Bits [OFF_W-1:0] select the word in the line, the next IDX_W bits select the main-array index, and the remaining upper bits are the tag. Distinct addresses never alias.
- R3: All victim entries are compared with the request's line address in parallel, and at most one entry matches.
- R4: On a victim-buffer hit, the victim line and the main line exchange places. req_ready_o rises exactly two cycles after the cycle the request was first presented, and no memory request is issued.
- R5: A miss in both structures issues one memory read whose address is req_addr_i >> OFF_W. Ready follows in the cycle after the response, and the data comes from the returned line.
- R6: On a refill, a valid displaced main line (dirty bit kept) is placed in the victim buffer, so a later access to it hits there.
- R7: The victim slot for a refill is the lowest-numbered invalid entry. When all entries are valid, a rotating pointer (starting at entry 0 after reset) picks the slot and advances by one for each overwrite.
- R8: A victim entry that is valid and dirty when it is overwritten is first written to memory (write request with its line address and contents). The read request follows only after that. Clean entries are dropped without any memory traffic.
- R9: A memory request keeps valid, write flag and address stable until it is accepted with mem_req_ready_i.
- R10: Alternating accesses to two addresses with the same index cause exactly two memory reads in total.
- R11: After reset every line is invalid: req_ready_o and mem_req_valid_o are low, and the first access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present, held until ready |
| req_addr_i | input | ADDR_W | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| req_rdata_o | output | DATA_W | Read data, valid while req_ready_o is high |
| req_ready_o | output | 1 | Request completes at this clock edge |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_req_write_o | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr_o | output | ADDR_W-OFF_W | Line address |
| mem_req_line_o | output | WORDS*DATA_W | Write-back line contents |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_resp_valid_i | input | 1 | Read line returned this cycle |
| mem_resp_line_i | input | WORDS*DATA_W | Returned line contents |

## Verification
Properties checked on every cycle: ready never appears without a request, at most one victim entry matches, a victim hit leads to a quiet swap cycle and then to ready, a memory request stays stable until it is accepted, a write-back is followed directly by its read, and a response leads to ready. Only the bench's scenarios can show the rest. These are the data contents across swaps, refills and write-backs (checked against a shadow memory), the slot-choice order shown by which later accesses hit the buffer, the write-back contents, and the total refill count for the alternating pattern.

// File: rtl/vc_cache_pkg.sv
package vc_cache_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SWAP, ST_WB, ST_FETCH, ST_WAIT} vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 7,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o,
  input  logic              wr_en_i,
  input  logic              wr_dirty_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] line_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx_i]  <= wr_tag_i;
      line_q[idx_i] <= wr_line_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign line_o  = line_q[idx_i];
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ENTRIES = 4,
  parameter int LADDR_W = 10,
  parameter int LINE_W  = 128,
  localparam int SEL_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LADDR_W-1:0] lookup_i,
  output logic [ENTRIES-1:0] hit_vec_o,
  output logic               hit_o,
  output logic [SEL_W-1:0]   hit_sel_o,
  output logic               hit_dirty_o,
  output logic [LINE_W-1:0]  hit_line_o,
  output logic [SEL_W-1:0]   alloc_sel_o,
  output logic               alloc_valid_o,
  output logic               alloc_dirty_o,
  output logic [LADDR_W-1:0] alloc_laddr_o,
  output logic [LINE_W-1:0]  alloc_line_o,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic               wr_valid_i,
  input  logic               wr_dirty_i,
  input  logic [LADDR_W-1:0] wr_laddr_i,
  input  logic [LINE_W-1:0]  wr_line_i,
  input  logic               alloc_commit_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [LADDR_W-1:0] laddr_q [ENTRIES];
  logic [LINE_W-1:0]  line_q  [ENTRIES];
  logic [SEL_W-1:0]   ptr_q;
  logic               full;

  assign full = &valid_q;

  // one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_q[g] && (laddr_q[g] == lookup_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_sel_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec_o[i]) hit_sel_o = SEL_W'(i);
  end

  // lowest invalid entry wins, else rotating pointer
  always_comb begin
    alloc_sel_o = ptr_q;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) alloc_sel_o = SEL_W'(i);
  end

  assign hit_dirty_o   = dirty_q[hit_sel_o];
  assign hit_line_o    = line_q[hit_sel_o];
  assign alloc_valid_o = valid_q[alloc_sel_o];
  assign alloc_dirty_o = dirty_q[alloc_sel_o];
  assign alloc_laddr_o = laddr_q[alloc_sel_o];
  assign alloc_line_o  = line_q[alloc_sel_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (wr_en_i) begin
        valid_q[wr_sel_i] <= wr_valid_i;
        dirty_q[wr_sel_i] <= wr_dirty_i;
      end
      if (alloc_commit_i && full)
        ptr_q <= (ptr_q == SEL_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      laddr_q[wr_sel_i] <= wr_laddr_i;
      line_q[wr_sel_i]  <= wr_line_i;
    end
  end
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_cache_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  input  logic      main_hit_i,
  input  logic      victim_hit_i,
  input  logic      need_wb_i,
  input  logic      mem_ready_i,
  input  logic      mem_resp_i,
  output vc_state_e state_o
);
  vc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (req_valid_i && !main_hit_i)
          state_d = victim_hit_i ? ST_SWAP : (need_wb_i ? ST_WB : ST_FETCH);
      ST_SWAP:  state_d = ST_IDLE;
      ST_WB:    if (mem_ready_i) state_d = ST_FETCH;
      ST_FETCH: if (mem_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (mem_resp_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/vc_cache_top.sv
module vc_cache_top
  import vc_cache_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int LINES   = 8,
  parameter int VICTIMS = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int TAG_W   = LADDR_W - IDX_W,
  localparam int LINE_W  = WORDS * DATA_W,
  localparam int SEL_W   = $clog2(VICTIMS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_we_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic [DATA_W-1:0]  req_rdata_o,
  output logic               req_ready_o,
  output logic               mem_req_valid_o,
  output logic               mem_req_write_o,
  output logic [LADDR_W-1:0] mem_req_addr_o,
  output logic [LINE_W-1:0]  mem_req_line_o,
  input  logic               mem_req_ready_i,
  input  logic               mem_resp_valid_i,
  input  logic [LINE_W-1:0]  mem_resp_line_i
);
  logic [OFF_W-1:0]   req_off;
  logic [IDX_W-1:0]   req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic [LADDR_W-1:0] req_laddr;

  assign req_off   = req_addr_i[OFF_W-1:0];
  assign req_idx   = req_addr_i[OFF_W +: IDX_W];
  assign req_tag   = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_laddr = req_addr_i[ADDR_W-1:OFF_W];

  logic              m_valid, m_dirty, m_wr_en, m_wr_dirty;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_line, m_wr_line, merged_line;
  logic              main_hit;

  logic [VICTIMS-1:0] v_hit_vec;
  logic               v_hit, v_hit_dirty, v_alloc_valid, v_alloc_dirty;
  logic [SEL_W-1:0]   v_hit_sel, v_alloc_sel, v_wr_sel;
  logic [LINE_W-1:0]  v_hit_line, v_alloc_line;
  logic [LADDR_W-1:0] v_alloc_laddr;
  logic               v_wr_en, v_commit;

  vc_state_e state;
  logic      hit_ok, do_swap, do_refill, need_wb;

  vc_main_array #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
    .clk_i, .rst_ni,
    .idx_i      (req_idx),
    .valid_o    (m_valid),
    .dirty_o    (m_dirty),
    .tag_o      (m_tag),
    .line_o     (m_line),
    .wr_en_i    (m_wr_en),
    .wr_dirty_i (m_wr_dirty),
    .wr_tag_i   (req_tag),
    .wr_line_i  (m_wr_line)
  );

  vc_victim_buf #(.ENTRIES(VICTIMS), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_victim (
    .clk_i, .rst_ni,
    .lookup_i       (req_laddr),
    .hit_vec_o      (v_hit_vec),
    .hit_o          (v_hit),
    .hit_sel_o      (v_hit_sel),
    .hit_dirty_o    (v_hit_dirty),
    .hit_line_o     (v_hit_line),
    .alloc_sel_o    (v_alloc_sel),
    .alloc_valid_o  (v_alloc_valid),
    .alloc_dirty_o  (v_alloc_dirty),
    .alloc_laddr_o  (v_alloc_laddr),
    .alloc_line_o   (v_alloc_line),
    .wr_en_i        (v_wr_en),
    .wr_sel_i       (v_wr_sel),
    .wr_valid_i     (m_valid),
    .wr_dirty_i     (m_dirty),
    .wr_laddr_i     ({m_tag, req_idx}),
    .wr_line_i      (m_line),
    .alloc_commit_i (v_commit)
  );

  vc_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i  (req_valid_i),
    .main_hit_i   (main_hit),
    .victim_hit_i (v_hit),
    .need_wb_i    (need_wb),
    .mem_ready_i  (mem_req_ready_i),
    .mem_resp_i   (mem_resp_valid_i),
    .state_o      (state)
  );

  assign main_hit  = m_valid && (m_tag == req_tag);
  assign hit_ok    = (state == ST_IDLE) && req_valid_i && main_hit;
  assign do_swap   = (state == ST_SWAP);
  assign do_refill = (state == ST_WAIT) && mem_resp_valid_i;
  // only a displaced valid line can push out a dirty victim
  assign need_wb   = m_valid && v_alloc_valid && v_alloc_dirty;

  always_comb begin
    merged_line = m_line;
    merged_line[req_off*DATA_W +: DATA_W] = req_wdata_i;
  end

  assign m_wr_en    = (hit_ok && req_we_i) || do_swap || do_refill;
  assign m_wr_dirty = do_swap ? v_hit_dirty : !do_refill;
  assign m_wr_line  = do_swap ? v_hit_line : (do_refill ? mem_resp_line_i : merged_line);

  // swap may write an invalid main line into the hit slot, freeing it
  assign v_wr_en  = do_swap || (do_refill && m_valid);
  assign v_wr_sel = do_swap ? v_hit_sel : v_alloc_sel;
  assign v_commit = do_refill && m_valid;

  assign req_ready_o     = hit_ok;
  assign req_rdata_o     = m_line[req_off*DATA_W +: DATA_W];
  assign mem_req_valid_o = (state == ST_WB) || (state == ST_FETCH);
  assign mem_req_write_o = (state == ST_WB);
  assign mem_req_addr_o  = (state == ST_WB) ? v_alloc_laddr : req_laddr;
  assign mem_req_line_o  = v_alloc_line;
endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk
  import vc_cache_pkg::*;
#(
  parameter int LADDR_W = 10,
  parameter int VICTIMS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               mem_req_valid_o,
  input logic               mem_req_write_o,
  input logic [LADDR_W-1:0] mem_req_addr_o,
  input logic               mem_req_ready_i,
  input logic               mem_resp_valid_i,
  input vc_state_e          state_i,
  input logic [VICTIMS-1:0] vhit_vec_i,
  input logic               main_hit_i
);
  a_r1_ready_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> req_valid_i);

  a_r3_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vhit_vec_i));

  a_r4_quiet_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && req_valid_i && !main_hit_i && (|vhit_vec_i))
      |=> (!mem_req_valid_o ##1 req_ready_o));

  a_r5_ready_after_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT && mem_resp_valid_i) |=> req_ready_o);

  a_r8_wb_then_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_write_o && mem_req_ready_i)
      |=> (mem_req_valid_o && !mem_req_write_o));

  a_r9_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i)
      |=> (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)));
endmodule

bind vc_cache_top vc_cache_chk #(.LADDR_W(LADDR_W), .VICTIMS(VICTIMS)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_ready_o      (req_ready_o),
  .mem_req_valid_o  (mem_req_valid_o),
  .mem_req_write_o  (mem_req_write_o),
  .mem_req_addr_o   (mem_req_addr_o),
  .mem_req_ready_i  (mem_req_ready_i),
  .mem_resp_valid_i (mem_resp_valid_i),
  .state_i          (state),
  .vhit_vec_i       (v_hit_vec),
  .main_hit_i       (main_hit)
);

// File: tb/sim_vc_cache_top.sv
`timescale 1ns/1ps
module sim_vc_cache_top;
  localparam int ADDR_W = 12, DATA_W = 32, WORDS = 4, LINES = 8, VICTIMS = 4;
  localparam int OFF_W = 2, IDX_W = 3, LADDR_W = ADDR_W - OFF_W, LINE_W = WORDS * DATA_W;
  localparam int NLINES = 1 << LADDR_W, NWORDS = 1 << ADDR_W, LAT = 10;
  localparam int K_HIT = 0, K_VIC = 1, K_MISS = 2, K_ANY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, req_rdata;
  logic req_ready, mreq_valid, mreq_write, mreq_ready, mresp_valid;
  logic [LADDR_W-1:0] mreq_addr;
  logic [LINE_W-1:0] mreq_line, mresp_line;

  always #2.5 clk = ~clk;

  vc_cache_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES), .VICTIMS(VICTIMS)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_we_i(req_we),
    .req_wdata_i(req_wdata), .req_rdata_o(req_rdata), .req_ready_o(req_ready),
    .mem_req_valid_o(mreq_valid), .mem_req_write_o(mreq_write), .mem_req_addr_o(mreq_addr),
    .mem_req_line_o(mreq_line), .mem_req_ready_i(mreq_ready),
    .mem_resp_valid_i(mresp_valid), .mem_resp_line_i(mresp_line)
  );

  int n_checks = 0, n_errors = 0;
  bit finished = 0;
  logic [DATA_W-1:0] shadow [NWORDS];
  logic [LINE_W-1:0] mem [NLINES];
  int rd_cnt = 0, wb_cnt = 0, wb_at_rd = 0, pend = 0;
  logic [LADDR_W-1:0] last_rd, last_wb, hold_addr, pend_addr;
  bit hold_seen = 0;

  function automatic logic [DATA_W-1:0] init_word(input int a);
    return (32'(a) * 32'h0100_0193) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [LINE_W-1:0] shadow_line(input int la);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < WORDS; w++) l[w*DATA_W +: DATA_W] = shadow[la*WORDS + w];
    return l;
  endfunction

  function automatic int mk(input int tag, input int idx, input int off);
    return (tag << (OFF_W + IDX_W)) | (idx << OFF_W) | off;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // memory model: decisions at negedge, take effect at next posedge
  always @(negedge clk) begin
    if (!rst_n) begin
      mreq_ready = 0; mresp_valid = 0; mresp_line = '0; pend = 0; hold_seen = 0;
    end else begin
      mresp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mresp_valid = 1; mresp_line = mem[pend_addr]; end
      end
      mreq_ready = 0;
      if (mreq_valid) begin
        if (!hold_seen) begin
          hold_seen = 1; hold_addr = mreq_addr;
        end else begin
          check(mreq_addr == hold_addr, "R9 request held", 64'(mreq_addr), 64'(hold_addr));
          mreq_ready = 1; hold_seen = 0;
          if (mreq_write) begin
            wb_cnt++; last_wb = mreq_addr;
            check(mreq_line == shadow_line(int'(mreq_addr)), "R8 write-back data",
                  64'(mreq_line), 64'(shadow_line(int'(mreq_addr))));
            mem[mreq_addr] = mreq_line;
          end else begin
            rd_cnt++; last_rd = mreq_addr; wb_at_rd = wb_cnt;
            pend_addr = mreq_addr; pend = LAT;
          end
        end
      end
    end
  end

  task automatic access(input int a, input bit we, input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd, output int cyc);
    req_valid = 1; req_addr = ADDR_W'(a); req_we = we; req_wdata = wd; cyc = 0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; cyc++; end
    rd = req_rdata;
    @(negedge clk);
    req_valid = 0; req_we = 0;
    if (we) shadow[a] = wd;
  endtask

  task automatic op(input int a, input bit we, input logic [DATA_W-1:0] wd, input int kind, input string rq);
    logic [DATA_W-1:0] rd;
    int cyc, rd0;
    rd0 = rd_cnt;
    access(a, we, wd, rd, cyc);
    if (!we) check(rd == shadow[a], {rq, " data"}, 64'(rd), 64'(shadow[a]));
    case (kind)
      K_HIT:  check(cyc == 0, {rq, " hit latency"}, 64'(cyc), 0);
      K_VIC: begin
        check(cyc == 2, {rq, " swap latency"}, 64'(cyc), 2);
        check(rd_cnt == rd0, {rq, " no refill on swap"}, 64'(rd_cnt), 64'(rd0));
      end
      K_MISS: begin
        check(rd_cnt == rd0 + 1, {rq, " one refill"}, 64'(rd_cnt), 64'(rd0 + 1));
        check(last_rd == LADDR_W'(a >> OFF_W), {rq, " refill address"}, 64'(last_rd), 64'(a >> OFF_W));
      end
      default: ;
    endcase
  endtask

  task automatic do_reset();
    req_valid = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int a, b, wb0, rd0;
    for (int i = 0; i < NWORDS; i++) shadow[i] = init_word(i);
    for (int l = 0; l < NLINES; l++) mem[l] = shadow_line(l);

    do_reset();
    #1;
    check(req_ready == 0, "R11 ready after reset", 64'(req_ready), 0);
    check(mreq_valid == 0, "R11 mem idle after reset", 64'(mreq_valid), 0);
    @(negedge clk);

    // ping-pong on index 0
    a = mk(3, 0, 1); b = mk(4, 0, 1);
    op(a, 0, 0, K_MISS, "R11 first access");
    op(mk(3, 0, 3), 0, 0, K_HIT, "R1 read hit");
    op(mk(3, 0, 2), 1, 32'hA5A5_0001, K_HIT, "R1 write hit");
    op(mk(3, 0, 2), 0, 0, K_HIT, "R1 read after write");
    op(b, 0, 0, K_MISS, "R5 conflict miss");
    op(a, 0, 0, K_VIC, "R6 displaced line in buffer");
    op(mk(3, 0, 2), 0, 0, K_HIT, "R4 dirty data kept across swap");
    for (int k = 0; k < 8; k++) begin
      op(b, 0, 0, K_VIC, "R4 ping");
      op(a, (k == 3), 32'hBEEF_0000 + 32'(k), K_VIC, "R4 pong");
    end
    check(rd_cnt == 2, "R10 total refills", 64'(rd_cnt), 2);

    // replacement order on index 1, tags 10..15
    do_reset();
    for (int t = 10; t < 15; t++) op(mk(t, 1, 0), 0, 0, K_MISS, "R7 fill");
    op(mk(15, 1, 0), 0, 0, K_MISS, "R7 full miss");
    op(mk(11, 1, 0), 0, 0, K_VIC, "R3 match entry 1");
    op(mk(10, 1, 0), 0, 0, K_MISS, "R7 oldest dropped");
    op(mk(12, 1, 0), 0, 0, K_VIC, "R3 match entry 2");
    op(mk(15, 1, 0), 0, 0, K_MISS, "R7 pointer advanced");
    op(mk(14, 1, 0), 0, 0, K_VIC, "R7 survivor in buffer");

    // dirty victim write-back on index 2, tags 20..26
    do_reset();
    op(mk(20, 2, 3), 1, 32'h1234_5678, K_MISS, "R8 write miss");
    for (int t = 21; t < 25; t++) op(mk(t, 2, 0), 0, 0, K_MISS, "R8 fill");
    wb0 = wb_cnt;
    check(wb0 == 0, "R8 no early write-back", 64'(wb0), 0);
    op(mk(25, 2, 0), 0, 0, K_MISS, "R8 evict dirty");
    check(wb_cnt == 1, "R8 write-back count", 64'(wb_cnt), 1);
    check(last_wb == LADDR_W'(mk(20, 2, 0) >> OFF_W), "R8 write-back address",
          64'(last_wb), 64'(mk(20, 2, 0) >> OFF_W));
    check(wb_at_rd == 1, "R8 write-back before read", 64'(wb_at_rd), 1);
    op(mk(26, 2, 0), 0, 0, K_MISS, "R8 evict clean");
    check(wb_cnt == 1, "R8 clean drop silent", 64'(wb_cnt), 1);
    op(mk(20, 2, 3), 0, 0, K_MISS, "R8 written data from memory");

    // address split sweep: tags 40..45 all indices, write then read every word
    do_reset();
    for (int t = 40; t < 46; t++)
      for (int i = 0; i < LINES; i++)
        op(mk(t, i, (t + i) % WORDS), 1, 32'(t * 256 + i), K_ANY, "R2 sweep write");
    for (int t = 40; t < 46; t++)
      for (int i = 0; i < LINES; i++)
        for (int w = 0; w < WORDS; w++)
          op(mk(t, i, w), 0, 0, K_ANY, "R2 sweep read");

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule